// File: doc/BRIEF.md
# ADC channel scan sequencer

This block walks an eight-input analog converter through a contiguous range of input channels. Software places a first channel and a last channel into two 3-bit fields through a simple write port. A trigger then starts the scan. For each channel the sequencer drives the multiplexer select, waits a cycle so the analog path can settle, and issues a one-clock start-conversion strobe. It then waits for the converter's done strobe before it moves on. When the first channel is numerically above the last one, the range runs up to channel 7, wraps to channel 0 and continues from there.

There are three run modes. A single scan converts the range once, flags the end of the scan and goes idle. A continuous scan loops back to the first channel forever, until reset. A paused scan stops after every converted channel and waits for a further trigger before it moves to the next channel. A readable channel field always shows the channel being converted, or the one converted last. It never shows the value most recently written to the first-channel field.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, ch_sel_o and ch_rd_o are 0, and busy_o, conv_start_o, scan_end_o and wr_err_o are all low.
- R2: When the first channel is below the last channel, the channels are converted in rising order from first to last, both included.
- R3: When the first channel equals the last channel, exactly one channel is converted.
- R4: When the first channel is above the last channel, the channels run from first up to 7, then from 0 up to last.
- R5: In continuous mode (mode_i = 01) and pause mode (mode_i = 10), the channel converted after the last channel is the first channel again, and busy_o stays high.
- R6: scan_end_o is high for exactly one cycle, on the edge after done_i is seen for the last channel, in every mode. In single mode (mode_i = 00 or 11), busy_o falls on that same edge.
- R7: In pause mode, after each done_i the sequencer issues no strobe and keeps busy_o high until trig_i is seen. The next conversion then uses the following channel in the range.
- R8: A trigger seen while idle loads the first channel into ch_sel_o on the next edge. conv_start_o is one cycle wide and rises one edge after ch_sel_o takes a new channel.
- R9: ch_rd_o shows the channel being converted, or the last one converted. Writing the first-channel field (wr_sel_i = 0) while idle leaves ch_rd_o unchanged.
- R10: A write (wr_en_i) while busy_o is high changes neither field. It sets wr_err_o, and wr_err_o stays set until reset.
- R11: done_i has no effect unless a conversion is outstanding. trig_i has no effect during a single or continuous scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start trigger; also resumes a paused scan |
| mode_i | input | 2 | Run mode, sampled at start: 00/11 single, 01 continuous, 10 pause |
| wr_en_i | input | 1 | Field write enable |
| wr_sel_i | input | 1 | Field select: 0 first channel, 1 last channel |
| wr_data_i | input | CH_W | Channel number to write |
| done_i | input | 1 | Conversion finished strobe from the converter |
| ch_sel_o | output | CH_W | Multiplexer channel select |
| conv_start_o | output | 1 | Start-conversion strobe, one cycle |
| busy_o | output | 1 | A scan is in progress (including a pause) |
| scan_end_o | output | 1 | Last channel of the range completed |
| ch_rd_o | output | CH_W | Readable channel field |
| wr_err_o | output | 1 | Sticky flag for a write attempted while busy |

## Verification
A trigger or a write is seen on a rising edge. ch_sel_o, ch_rd_o, busy_o and wr_err_o take their new values on that same edge. conv_start_o follows one edge later, and scan_end_o and the next channel select appear on the edge after done_i is seen. The bench drives its inputs on falling edges and runs a behavioural model that advances on each rising edge. It compares every output with that model on the following falling edge, so each result is checked in the cycle it becomes due. On top of this, the channel orders seen at each strobe are collected and compared with hand-worked lists.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    RUN_SINGLE = 2'b00,
    RUN_LOOP   = 2'b01,
    RUN_PAUSE  = 2'b10
  } run_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETTLE = 2'b01,
    PH_WAIT   = 2'b10,
    PH_HOLD   = 2'b11
  } scan_phase_e;

  function automatic run_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'b01:   return RUN_LOOP;
      2'b10:   return RUN_PAUSE;
      default: return RUN_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/adc_scan_cfg.sv
module adc_scan_cfg #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [CH_W-1:0] wr_data_i,
  input  logic            busy_i,
  output logic [CH_W-1:0] first_o,
  output logic [CH_W-1:0] last_o,
  output logic            err_o
);

  localparam logic [CH_W-1:0] MAX_CH = CH_W'(NUM_CH - 1);

  logic in_range;
  assign in_range = (wr_data_i <= MAX_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_o <= '0;
      last_o  <= '0;
      err_o   <= 1'b0;
    end else if (wr_en_i) begin
      if (busy_i) begin
        err_o <= 1'b1;
      end else if (in_range) begin
        if (wr_sel_i) last_o  <= wr_data_i;
        else          first_o <= wr_data_i;
      end
    end
  end

endmodule

// File: rtl/adc_scan_step.sv
module adc_scan_step #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [CH_W-1:0] cur_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] next_o,
  output logic            at_last_o
);

  localparam logic [CH_W-1:0] MAX_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] inc;

  generate
    if ((1 << CH_W) == NUM_CH) begin : g_pow2
      assign inc = cur_i + 1'b1;
    end else begin : g_mod
      assign inc = (cur_i == MAX_CH) ? '0 : cur_i + 1'b1;
    end
  endgenerate

  assign at_last_o = (cur_i == last_i);
  assign next_o    = at_last_o ? first_i : inc;

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic [1:0]      mode_i,
  input  logic            done_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] next_i,
  input  logic            at_last_i,
  output logic [CH_W-1:0] sel_o,
  output logic            strobe_o,
  output logic            busy_o,
  output logic            eos_o
);

  scan_phase_e     phase_q;
  run_mode_e       mode_q;
  logic [CH_W-1:0] resume_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      mode_q   <= RUN_SINGLE;
      sel_o    <= '0;
      resume_q <= '0;
      busy_o   <= 1'b0;
      strobe_o <= 1'b0;
      eos_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      eos_o    <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (trig_i) begin
            mode_q  <= decode_mode(mode_i);
            sel_o   <= first_i;
            busy_o  <= 1'b1;
            phase_q <= PH_SETTLE;
          end
        end
        PH_SETTLE: begin
          strobe_o <= 1'b1;
          phase_q  <= PH_WAIT;
        end
        PH_WAIT: begin
          if (done_i) begin
            eos_o <= at_last_i;
            if (at_last_i && mode_q == RUN_SINGLE) begin
              busy_o  <= 1'b0;
              phase_q <= PH_IDLE;
            end else if (mode_q == RUN_PAUSE) begin
              resume_q <= next_i;
              phase_q  <= PH_HOLD;
            end else begin
              sel_o   <= next_i;
              phase_q <= PH_SETTLE;
            end
          end
        end
        PH_HOLD: begin
          if (trig_i) begin
            sel_o   <= resume_q;
            phase_q <= PH_SETTLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter  int NUM_CH = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic [1:0]      mode_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [CH_W-1:0] wr_data_i,
  input  logic            done_i,
  output logic [CH_W-1:0] ch_sel_o,
  output logic            conv_start_o,
  output logic            busy_o,
  output logic            scan_end_o,
  output logic [CH_W-1:0] ch_rd_o,
  output logic            wr_err_o
);

  logic [CH_W-1:0] first_ch, last_ch, next_ch, cur_ch;
  logic            at_last;

  adc_scan_cfg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .busy_i    (busy_o),
    .first_o   (first_ch),
    .last_o    (last_ch),
    .err_o     (wr_err_o)
  );

  adc_scan_step #(.NUM_CH(NUM_CH), .CH_W(CH_W)) step_i (
    .cur_i     (cur_ch),
    .first_i   (first_ch),
    .last_i    (last_ch),
    .next_o    (next_ch),
    .at_last_o (at_last)
  );

  adc_scan_fsm #(.CH_W(CH_W)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (trig_i),
    .mode_i    (mode_i),
    .done_i    (done_i),
    .first_i   (first_ch),
    .next_i    (next_ch),
    .at_last_i (at_last),
    .sel_o     (cur_ch),
    .strobe_o  (conv_start_o),
    .busy_o    (busy_o),
    .eos_o     (scan_end_o)
  );

  assign ch_sel_o = cur_ch;
  assign ch_rd_o  = cur_ch;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            trig_i,
  input logic            done_i,
  input logic            wr_en_i,
  input logic [CH_W-1:0] ch_sel_o,
  input logic [CH_W-1:0] ch_rd_o,
  input logic            conv_start_o,
  input logic            busy_o,
  input logic            scan_end_o,
  input logic            wr_err_o
);

  p_strobe_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  p_strobe_after_select_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !$stable(ch_sel_o)) |=> conv_start_o);

  p_strobe_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> busy_o);

  p_end_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_end_o) |-> $past(done_i));

  p_end_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    scan_end_o |=> !scan_end_o);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |=> wr_err_o);

  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_err_o) |-> ($past(wr_en_i) && $past(busy_o)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !trig_i) |=> $stable(ch_rd_o));

endmodule

bind adc_scan_seq adc_scan_chk #(.CH_W(CH_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .trig_i       (trig_i),
  .done_i       (done_i),
  .wr_en_i      (wr_en_i),
  .ch_sel_o     (ch_sel_o),
  .ch_rd_o      (ch_rd_o),
  .conv_start_o (conv_start_o),
  .busy_o       (busy_o),
  .scan_end_o   (scan_end_o),
  .wr_err_o     (wr_err_o)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [2:0] wr_data_i = 3'd0;
  logic       conv_done = 1'b0;
  logic       spur_done = 1'b0;
  logic       done_i;
  logic [2:0] ch_sel_o, ch_rd_o;
  logic       conv_start_o, busy_o, scan_end_o, wr_err_o;

  assign done_i = conv_done | spur_done;

  always #4 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst(rst), .trig_i(trig_i), .mode_i(mode_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .done_i(done_i), .ch_sel_o(ch_sel_o), .conv_start_o(conv_start_o),
    .busy_o(busy_o), .scan_end_o(scan_end_o), .ch_rd_o(ch_rd_o),
    .wr_err_o(wr_err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int seq[$];
  int eos_cnt = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // converter stand-in: done pulse LAT cycles after each strobe
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) conv_done = 1'b1;
      end
      if (conv_start_o) cnt = LAT;
    end
  end

  // sequence recorder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && conv_start_o) seq.push_back(int'(ch_sel_o));
      if (!rst && scan_end_o) eos_cnt++;
    end
  end

  // behavioural reference: phase 0 idle, 1 settle, 2 converting, 3 held
  int m_ph, m_mode, m_first, m_last, m_ch, m_resume;
  int e_cs, e_busy, e_eos, e_err;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_mode = 0; m_first = 0; m_last = 0; m_ch = 0; m_resume = 0;
      e_cs = 0; e_busy = 0; e_eos = 0; e_err = 0;
    end else begin
      e_cs = 0; e_eos = 0;
      if (wr_en_i) begin
        if (m_ph != 0) e_err = 1;
        else if (wr_sel_i) m_last = int'(wr_data_i);
        else m_first = int'(wr_data_i);
      end
      if (m_ph == 0) begin
        if (trig_i) begin
          m_mode = (mode_i == 2'b01) ? 1 : (mode_i == 2'b10) ? 2 : 0;
          m_ch = m_first; e_busy = 1; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        e_cs = 1; m_ph = 2;
      end else if (m_ph == 2) begin
        if (done_i) begin
          int nx;
          nx = (m_ch == m_last) ? m_first : (m_ch + 1) % 8;
          e_eos = (m_ch == m_last) ? 1 : 0;
          if (m_ch == m_last && m_mode == 0) begin e_busy = 0; m_ph = 0; end
          else if (m_mode == 2) begin m_resume = nx; m_ph = 3; end
          else begin m_ch = nx; m_ph = 1; end
        end
      end else begin
        if (trig_i) begin m_ch = m_resume; m_ph = 1; end
      end
    end
  end

  // per-cycle comparison away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        check("R8 ch_sel", int'(ch_sel_o), m_ch);
        check("R8 conv_start", int'(conv_start_o), e_cs);
        check("R7 busy", int'(busy_o), e_busy);
        check("R6 scan_end", int'(scan_end_o), e_eos);
        check("R9 ch_rd", int'(ch_rd_o), m_ch);
        check("R10 wr_err", int'(wr_err_o), e_err);
      end
    end
  end

  task automatic wr(input logic sel, input int val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = 3'(val);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_seq(input string req, input int exp[$]);
    check({req, " length"}, seq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < seq.size(); i++)
      check({req, " order"}, seq[i], exp[i]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle_cycles(2);
    rst = 1'b0;
  endtask

  task automatic single_scan(input int f, input int l);
    wr(1'b0, f); wr(1'b1, l);
    mode_i = 2'b00;
    seq.delete(); eos_cnt = 0;
    pulse_trig();
    idle_cycles(2);
    wait_idle();
    idle_cycles(2);
  endtask

  initial begin
    idle_cycles(3);
    // R1 reset values
    check("R1 ch_sel", int'(ch_sel_o), 0);
    check("R1 ch_rd", int'(ch_rd_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 strobe", int'(conv_start_o), 0);
    check("R1 scan_end", int'(scan_end_o), 0);
    check("R1 err", int'(wr_err_o), 0);
    rst = 1'b0;
    idle_cycles(2);

    // R2 rising range
    single_scan(2, 5);
    check_seq("R2", '{2, 3, 4, 5});
    check("R6 one end pulse", eos_cnt, 1);
    // R3 single channel
    single_scan(3, 3);
    check_seq("R3", '{3});
    // R4 wrap through 7 to 0
    single_scan(6, 1);
    check_seq("R4", '{6, 7, 0, 1});
    check("R6 idle after end", int'(busy_o), 0);
    // R9 write of first field while idle leaves readback
    wr(1'b0, 4);
    idle_cycles(1);
    check("R9 readback after write", int'(ch_rd_o), 1);
    // R11 stray done while idle
    @(negedge clk); spur_done = 1'b1;
    @(negedge clk); spur_done = 1'b0;
    idle_cycles(1);
    check("R11 stray done busy", int'(busy_o), 0);
    check("R11 stray done strobe", int'(conv_start_o), 0);

    // R10 write during scan, R11 extra trigger during scan
    wr(1'b0, 0); wr(1'b1, 2);
    mode_i = 2'b00; seq.delete(); eos_cnt = 0;
    pulse_trig();
    idle_cycles(2);
    wr(1'b0, 5);
    pulse_trig();
    wait_idle(); idle_cycles(2);
    check_seq("R10 R11 scan unaffected", '{0, 1, 2});
    check("R11 one end pulse", eos_cnt, 1);
    check("R10 err set", int'(wr_err_o), 1);
    seq.delete();
    pulse_trig(); idle_cycles(2); wait_idle(); idle_cycles(2);
    check_seq("R10 fields kept", '{0, 1, 2});
    check("R10 err sticky", int'(wr_err_o), 1);

    // R7 pause mode
    do_reset();
    check("R1 err cleared", int'(wr_err_o), 0);
    wr(1'b0, 1); wr(1'b1, 2);
    mode_i = 2'b10; seq.delete(); eos_cnt = 0;
    pulse_trig(); idle_cycles(10);
    check_seq("R7 halted after first", '{1});
    check("R7 busy in pause", int'(busy_o), 1);
    check("R9 readback in pause", int'(ch_rd_o), 1);
    idle_cycles(10);
    check_seq("R7 still halted", '{1});
    pulse_trig(); idle_cycles(10);
    check_seq("R7 advanced", '{1, 2});
    check("R6 end pulse in pause", eos_cnt, 1);
    pulse_trig(); idle_cycles(10);
    check_seq("R5 pause returns to first", '{1, 2, 1});

    // R5 continuous
    do_reset();
    wr(1'b0, 6); wr(1'b1, 7);
    mode_i = 2'b01; seq.delete();
    pulse_trig();
    for (int i = 0; i < 400 && seq.size() < 6; i++) @(negedge clk);
    check_seq("R5 continuous", '{6, 7, 6, 7, 6, 7});
    check("R5 busy held", int'(busy_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule